// File: doc/BRIEF.md
# Bounded precedence monitor

This block watches two event lines, a leading event and a lagging event, each sampled once per clock cycle. It checks that the leading event's occurrence count never falls behind the lagging event's count, and never runs more than `LEAD_MAX` occurrences ahead of it. It does this by keeping a small saturating difference register instead of two free-running counters. A mode input chooses between non-strict and strict ordering. In non-strict ordering, a lagging event may coincide with the leading event that matches it. In strict ordering, every lagging event must be matched by a leading event on an earlier cycle.

The monitor only observes. It never alters either event stream. On the first illegal step it raises a sticky violation flag and emits a one-cycle pulse. Its difference register then holds the last legal advance until the next synchronous reset. The current advance is available on an output for debug or for a downstream throttle.

Top module: `bounded_prec_monitor`

## Requirements
- R1: While `srst` is sampled high, `advance` is 0 and `violated` and `first_viol` are 0 on the following cycle.
- R2: Each output reflects the step sampled at the previous rising edge. On a legal step, lead alone raises `advance` by 1, lag alone lowers it by 1, and both together leave it unchanged.
- R3: A step with lead alone while `advance` equals `LEAD_MAX` is a violation, and `advance` never exceeds `LEAD_MAX`.
- R4: With `strict_mode` = 0, a step with lag alone at `advance` 0 is a violation. A step with lead and lag together is legal both at `advance` 0 and at `advance` `LEAD_MAX`.
- R5: With `strict_mode` = 1, any step with lag at `advance` 0 is a violation, even when lead occurs on the same step. A lag step at `advance` of 1 or more is legal.
- R6: A step with neither event changes neither `advance` nor `violated`.
- R7: Once set, `violated` stays 1 until a synchronous reset.
- R8: From the violating step onward, `advance` holds the last legal value it had before that step.
- R9: `first_viol` is 1 for exactly the one cycle after the first violating step, and stays 0 for every later violation until a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| srst | input | 1 | Synchronous reset, active high |
| strict_mode | input | 1 | 1 = strict ordering, 0 = non-strict ordering |
| lead_ev | input | 1 | Leading event occurs on this cycle |
| lag_ev | input | 1 | Lagging event occurs on this cycle |
| advance | output | $clog2(LEAD_MAX+1) | Leading count minus lagging count |
| violated | output | 1 | Sticky violation flag |
| first_viol | output | 1 | One-cycle pulse after the first violating step |

## Verification
The embedded properties assume that `srst` is a clean synchronous level and that the event lines have settled at each rising edge. They assume nothing about the ordering of events, so any event pattern is legal stimulus for them. The bench changes `strict_mode` only while reset is held, so each run has a single ordering rule. It drives every input on the falling edge, so that a step is unambiguous. The sweep covers every start advance, both modes and all four input combinations. A long pseudo-random phase then runs the block against a count-based reference.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

   // Kind of step seen on one sample cycle
   typedef enum logic [1:0] {
      STEP_IDLE = 2'b00,
      STEP_DOWN = 2'b01,
      STEP_UP   = 2'b10,
      STEP_BOTH = 2'b11
   } step_e;

   localparam int LEAD_MAX_MIN = 1;
   localparam int LEAD_MAX_MAX = 15;

endpackage

// File: rtl/bpm_step_classifier.sv
module bpm_step_classifier
   import bpm_pkg::*;
(
   input  logic  lead_ev,
   input  logic  lag_ev,
   output step_e step
);

   always_comb begin
      unique case ({lead_ev, lag_ev})
         2'b10:   step = STEP_UP;
         2'b01:   step = STEP_DOWN;
         2'b11:   step = STEP_BOTH;
         default: step = STEP_IDLE;
      endcase
   end

endmodule

// File: rtl/bpm_diff_tracker.sv
module bpm_diff_tracker
   import bpm_pkg::*;
#(
   parameter int LEAD_MAX = 3,
   parameter int W        = $clog2(LEAD_MAX + 1)
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         strict_mode,
   input  step_e        step,
   input  logic         halt,
   output logic [W-1:0] diff,
   output logic         viol_now
);

   localparam logic [W-1:0] DMAX = W'(LEAD_MAX);

   logic         at_floor;
   logic         at_ceil;
   logic [W-1:0] diff_nxt;

   assign at_floor = (diff == '0);
   assign at_ceil  = (diff == DMAX);

   always_comb begin
      unique case (step)
         STEP_UP:   viol_now = at_ceil;
         STEP_DOWN: viol_now = at_floor;
         STEP_BOTH: viol_now = strict_mode && at_floor;
         default:   viol_now = 1'b0;
      endcase
   end

   always_comb begin
      diff_nxt = diff;
      if (!halt && !viol_now) begin
         unique case (step)
            STEP_UP:   diff_nxt = diff + W'(1);
            STEP_DOWN: diff_nxt = diff - W'(1);
            default:   diff_nxt = diff;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (srst) diff <= '0;
      else      diff <= diff_nxt;
   end

   // R3
   adv_bound_chk: assert property (@(posedge clk) disable iff (srst)
      diff <= DMAX);

   // R2
   step_up_chk: assert property (@(posedge clk) disable iff (srst)
      (step == STEP_UP && !halt && diff != DMAX) |=> diff == $past(diff) + W'(1));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (srst)
      (step == STEP_IDLE) |=> $stable(diff));

   // R8
   frozen_chk: assert property (@(posedge clk) disable iff (srst)
      (halt || viol_now) |=> $stable(diff));

endmodule

// File: rtl/bpm_viol_latch.sv
module bpm_viol_latch (
   input  logic clk,
   input  logic srst,
   input  logic viol_now,
   output logic violated,
   output logic first_viol
);

   always_ff @(posedge clk) begin
      if (srst) begin
         violated   <= 1'b0;
         first_viol <= 1'b0;
      end else begin
         first_viol <= viol_now && !violated;
         violated   <= violated || viol_now;
      end
   end

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (srst)
      violated |=> violated);

   // R9
   pulse_once_chk: assert property (@(posedge clk) disable iff (srst)
      first_viol |=> !first_viol);

   // R9
   pulse_rise_chk: assert property (@(posedge clk) disable iff (srst)
      $rose(violated) |-> first_viol);

   // R9
   pulse_flag_chk: assert property (@(posedge clk) disable iff (srst)
      first_viol |-> violated);

endmodule

// File: rtl/bounded_prec_monitor.sv
module bounded_prec_monitor
   import bpm_pkg::*;
#(
   parameter int LEAD_MAX = 3,
   parameter int W        = $clog2(LEAD_MAX + 1)
) (
   input  logic         clk,
   input  logic         srst,
   input  logic         strict_mode,
   input  logic         lead_ev,
   input  logic         lag_ev,
   output logic [W-1:0] advance,
   output logic         violated,
   output logic         first_viol
);

   generate
      if (LEAD_MAX < LEAD_MAX_MIN || LEAD_MAX > LEAD_MAX_MAX) begin : g_bad_max
         $error("LEAD_MAX must lie in 1..15");
      end
      if (W != $clog2(LEAD_MAX + 1)) begin : g_bad_w
         $error("W must equal clog2(LEAD_MAX+1)");
      end
   endgenerate

   step_e step;
   logic  viol_now;

   bpm_step_classifier u_cls (
      .lead_ev (lead_ev),
      .lag_ev  (lag_ev),
      .step    (step)
   );

   bpm_diff_tracker #(.LEAD_MAX(LEAD_MAX), .W(W)) u_trk (
      .clk         (clk),
      .srst        (srst),
      .strict_mode (strict_mode),
      .step        (step),
      .halt        (violated),
      .diff        (advance),
      .viol_now    (viol_now)
   );

   bpm_viol_latch u_lat (
      .clk        (clk),
      .srst       (srst),
      .viol_now   (viol_now),
      .violated   (violated),
      .first_viol (first_viol)
   );

endmodule

// File: tb/bounded_prec_monitor_tb_top.sv
module bounded_prec_monitor_tb_top;

   localparam int LM = 3;
   localparam int W  = $clog2(LM + 1);

   logic         clk = 1'b0;
   logic         srst = 1'b1;
   logic         strict_mode = 1'b0;
   logic         lead_ev = 1'b0;
   logic         lag_ev = 1'b0;
   logic [W-1:0] advance;
   logic         violated;
   logic         first_viol;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int  ref_c1, ref_c2;
   bit  ref_viol, ref_pulse;

   always #5 clk = ~clk;

   bounded_prec_monitor #(.LEAD_MAX(LM)) dut_i (
      .clk         (clk),
      .srst        (srst),
      .strict_mode (strict_mode),
      .lead_ev     (lead_ev),
      .lag_ev      (lag_ev),
      .advance     (advance),
      .violated    (violated),
      .first_viol  (first_viol)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      srst = 1'b1; strict_mode = mode; lead_ev = 1'b0; lag_ev = 1'b0;
      @(posedge clk);
      @(negedge clk);
      srst = 1'b0;
      ref_c1 = 0; ref_c2 = 0; ref_viol = 0; ref_pulse = 0;
   endtask

   // Apply one step at the falling edge, predict, check after the next rising edge
   task automatic step(input bit a, input bit b, input string tag);
      int n1, n2;
      bit bad;
      lead_ev = a; lag_ev = b;
      n1 = ref_c1 + int'(a);
      n2 = ref_c2 + int'(b);
      if (strict_mode) bad = (b && ref_c1 <= ref_c2) || (n1 - n2 > LM);
      else             bad = (n1 < n2) || (n1 - n2 > LM);
      ref_pulse = 0;
      if (!ref_viol) begin
         if (bad) begin
            ref_viol  = 1;
            ref_pulse = 1;
         end else begin
            ref_c1 = n1; ref_c2 = n2;
         end
      end
      @(posedge clk);
      @(negedge clk);
      chk({tag, " advance"}, int'(advance), ref_c1 - ref_c2);
      chk("R7 violated", int'(violated), int'(ref_viol));
      chk("R9 first_viol", int'(first_viol), int'(ref_pulse));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      string tg;
      // R1: reset state, including a reset that lands after a violation
      do_reset(1'b0);
      chk("R1 advance", int'(advance), 0);
      chk("R1 violated", int'(violated), 0);
      chk("R1 first_viol", int'(first_viol), 0);
      step(1'b0, 1'b1, "R4");
      do_reset(1'b0);
      chk("R1 advance after violation", int'(advance), 0);
      chk("R1 violated after violation", int'(violated), 0);

      // Exhaustive sweep: mode x start advance x input pair
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s <= LM; s++) begin
            for (int c = 0; c < 4; c++) begin
               do_reset(m[0]);
               for (int k = 0; k < s; k++) step(1'b1, 1'b0, "R2");
               if (c == 0)                tg = "R6";
               else if (m == 1 && c[0])   tg = "R5";
               else if (c == 2 && s == LM) tg = "R3";
               else if (c[0])             tg = "R4";
               else                       tg = "R2";
               step(c[1], c[0], tg);
               // R8: further activity after any violation must leave advance frozen
               step(1'b1, 1'b0, "R8");
               step(1'b0, 1'b1, "R8");
               step(1'b0, 1'b0, "R6");
            end
         end
      end

      // R9: repeated violations give only one pulse
      do_reset(1'b0);
      step(1'b0, 1'b1, "R4");
      step(1'b0, 1'b1, "R9");
      step(1'b0, 1'b1, "R9");

      // Long pseudo-random phase against the count reference
      for (int r = 0; r < 3000; r++) begin
         int v;
         if (r % 150 == 0) do_reset(r[8]);
         v = $urandom_range(0, 9);
         // bias toward legal traffic so long runs stay alive
         if (v < 3)      step(1'b1, 1'b0, "R2");
         else if (v < 6) step(1'b0, 1'b1, "R2");
         else if (v < 8) step(1'b1, 1'b1, "R4");
         else            step(1'b0, 1'b0, "R6");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule